// File: doc/BRIEF.md
# Accessory ID auto-configuration controller

This controller sits between an ID-pin converter and the signal switches of a shared accessory connector. Each cycle it takes a 5-bit resistor-ID code, a VBUS-valid flag and an I/O-supply-present flag. From these it classifies the attached accessory and keeps the last code and the resulting device type in registers. It drives the switch-path select, the charger-FET enable, an open-drain charger-detect pull-down, and the two factory lines. The factory lines are a boot-level output and a jig pull-down. It also emits one-cycle attach, detach, key and change events toward an interrupt block.

Factory-jig accessories are configured as soon as they are seen. Every other accessory is configured only after two steps. First the host reads the interrupt, which is modelled as a one-cycle read strobe. Then a programmable number of ticks from a 1 kHz timebase must pass. Charger codes count as an accessory only while VBUS is valid. A headset with remote buttons stays configured while its button codes come and go, and each change is reported as a key event.

Top module: `acc_id_ctrl`

## Requirements
- R1: After reset the path select is 0 (open), the FET enable, charger-detect pull-down, boot level and jig pull-down are all 0, the code register reads 5'b11111, the device type reads 0 (none) and no event is raised.
- R2: When the input code differs from the code register, or when its classification differs from the device-type register, both registers take the new values on the next edge and changeEvt is high for exactly the following cycle.
- R3: Classification and device-type encoding: 00000 OTG=1; 00001..01101 and 11110 headset=2; 10011 UART headset=3; 10100 phone-powered device=4; 10110 UART cable=5; 11010 A/V cable=6; 10111/11011 charger=7; 11111 with VBUS USB=8; 11000=9, 11001=10, 11100=11, 11101=12 factory; 10101 TTY=13; every other code=0. Path encoding: 0 open, 1 USB, 2 UART, 3 audio, 4 video. The applied path is USB for types 1, 8, 9 and 10, UART for 3, 5, 11 and 12, audio for 2, 4 and 13, and video for 6. The FET is enabled for types 4, 7, 8, 9 and 10.
- R4: With the I/O supply present, a factory code is applied on the edge that sees it: jig pull-down 1, boot level 1 for 11001/11101 and 0 for 11000/11100, path USB or UART by code.
- R5: With the I/O supply absent, a factory code drives the jig pull-down and boot level at once but keeps the path open; the full configuration is applied on the edge after the supply is seen present.
- R6: A new non-factory accessory opens all paths and raises attachEvt. Its configuration is applied only after an intRead pulse and then waitTicks further tick1k pulses; waitTicks=0 applies it on the second edge after the read.
- R7: intRead is ignored unless the controller is waiting for the host read.
- R8: Codes 10111 and 11011 classify as none while VBUS is invalid. Once configured as a charger, the charger-detect pull-down and FET enable are 1 and the path is open. Losing VBUS releases both on the next edge.
- R9: A code change that keeps the headset type (type 2) raises keyEvt for one cycle and leaves the applied configuration unchanged.
- R10: A change to a code that classifies as none opens all paths, releases every output, clears the device type and raises detachEvt on the next edge.
- R11: Code 11111 is USB (type 8) with VBUS valid and none without it; code 11110 is the headset type in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| idCode | input | 5 | Resistor-ID code from the converter |
| vbusOk | input | 1 | VBUS within valid range |
| ioSupplyOk | input | 1 | Host I/O supply present |
| tick1k | input | 1 | One-cycle pulse per 1 ms |
| waitTicks | input | WAIT_W | Programmed switch wait in ticks |
| intRead | input | 1 | Host read of the interrupt, one cycle |
| pathSel | output | 3 | Switch-path select |
| chgFetOn | output | 1 | Charger FET enable |
| chgDetPullLow | output | 1 | Charger-detect open-drain pull-down |
| bootHigh | output | 1 | Factory boot level |
| jigPullLow | output | 1 | Factory jig open-drain pull-down |
| devType | output | 4 | Latched device type |
| adcValue | output | 5 | Latched ID code |
| changeEvt | output | 1 | Code or type changed |
| attachEvt | output | 1 | New accessory attached |
| detachEvt | output | 1 | Accessory removed |
| keyEvt | output | 1 | Headset button code changed |

## Verification
On every cycle the assertions check several invariants. Paths stay open while a read or the wait timer is pending. The charger-detect pull-down is active only with the charger type latched. A none type never leaves a path, FET or jig active. A boot level appears only with the jig pulled low. Key events occur only with the headset type, and an ignored read does not move the controller out of its configured state. The bench scenarios are needed to show the cycle-exact timing and the concrete values. These cover the read-then-count handshake against the 1 kHz ticks, factory configuration that skips that handshake and is deferred by a missing supply, charger reporting that follows VBUS, and key events that leave the configuration in place.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int ID_W = 5;

  typedef enum logic [3:0] {
    DEV_NONE = 4'd0, DEV_OTG = 4'd1, DEV_AUDIO1 = 4'd2, DEV_AUDIO2 = 4'd3,
    DEV_PPD = 4'd4, DEV_UART = 4'd5, DEV_AV = 4'd6, DEV_CHARGER = 4'd7,
    DEV_USB = 4'd8, DEV_JUSB_OFF = 4'd9, DEV_JUSB_ON = 4'd10,
    DEV_JUART_OFF = 4'd11, DEV_JUART_ON = 4'd12, DEV_TTY = 4'd13
  } devType_t;

  typedef enum logic [2:0] {
    PATH_OPEN = 3'd0, PATH_USB = 3'd1, PATH_UART = 3'd2,
    PATH_AUDIO = 3'd3, PATH_VIDEO = 3'd4
  } path_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_WAIT_READ, PH_WAIT_TIME, PH_JIG_HOLD, PH_ACTIVE
  } phase_t;

  typedef struct packed {
    path_t path;
    logic  fetOn;
    logic  chgLow;
    logic  bootHigh;
    logic  jigLow;
  } swCfg_t;

  typedef struct packed {
    logic latchCode;
    logic clearCfg;
    logic applyNew;
    logic applyCur;
    logic jigNew;
    logic loadTimer;
    logic pulseAttach;
    logic pulseDetach;
    logic pulseKey;
  } ctrlStrobe_t;

  function automatic devType_t classifyId(input logic [ID_W-1:0] code, input logic vbus);
    devType_t t;
    t = DEV_NONE;
    if (code == 5'b00000) t = DEV_OTG;
    else if (code <= 5'b01101) t = DEV_AUDIO1;
    else begin
      case (code)
        5'b10011: t = DEV_AUDIO2;
        5'b10100: t = DEV_PPD;
        5'b10101: t = DEV_TTY;
        5'b10110: t = DEV_UART;
        5'b10111, 5'b11011: t = vbus ? DEV_CHARGER : DEV_NONE;
        5'b11000: t = DEV_JUSB_OFF;
        5'b11001: t = DEV_JUSB_ON;
        5'b11010: t = DEV_AV;
        5'b11100: t = DEV_JUART_OFF;
        5'b11101: t = DEV_JUART_ON;
        5'b11110: t = DEV_AUDIO1;
        5'b11111: t = vbus ? DEV_USB : DEV_NONE;
        default:  t = DEV_NONE;
      endcase
    end
    return t;
  endfunction

  function automatic logic isFactory(input devType_t t);
    return (t == DEV_JUSB_OFF) || (t == DEV_JUSB_ON) ||
           (t == DEV_JUART_OFF) || (t == DEV_JUART_ON);
  endfunction

  function automatic swCfg_t cfgOf(input devType_t t);
    swCfg_t c;
    c = '0;
    case (t)
      DEV_OTG:     c.path = PATH_USB;
      DEV_AUDIO1:  c.path = PATH_AUDIO;
      DEV_AUDIO2:  c.path = PATH_UART;
      DEV_PPD:     begin c.path = PATH_AUDIO; c.fetOn = 1'b1; end
      DEV_TTY:     c.path = PATH_AUDIO;
      DEV_UART:    c.path = PATH_UART;
      DEV_AV:      c.path = PATH_VIDEO;
      DEV_CHARGER: begin c.fetOn = 1'b1; c.chgLow = 1'b1; end
      DEV_USB:     begin c.path = PATH_USB; c.fetOn = 1'b1; end
      DEV_JUSB_OFF, DEV_JUSB_ON: begin
        c.path = PATH_USB; c.fetOn = 1'b1; c.jigLow = 1'b1;
        c.bootHigh = (t == DEV_JUSB_ON);
      end
      DEV_JUART_OFF, DEV_JUART_ON: begin
        c.path = PATH_UART; c.jigLow = 1'b1;
        c.bootHigh = (t == DEV_JUART_ON);
      end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/acc_dp.sv
module acc_dp
  import acc_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ID_W-1:0]   idCode,
  input  logic              vbusOk,
  input  logic              tick1k,
  input  logic [WAIT_W-1:0] waitTicks,
  input  ctrlStrobe_t       strb,
  output devType_t          newType,
  output devType_t          curType,
  output logic              evtSeen,
  output logic              timerZero,
  output logic [ID_W-1:0]   adcValue,
  output swCfg_t            cfg,
  output logic              changeEvt,
  output logic              attachEvt,
  output logic              detachEvt,
  output logic              keyEvt
);
  logic [ID_W-1:0]   adcReg;
  devType_t          typeReg;
  swCfg_t            cfgReg, cfgNext, jigCfg;
  logic [WAIT_W-1:0] waitCnt;

  assign newType   = classifyId(idCode, vbusOk);
  assign evtSeen   = (idCode != adcReg) || (newType != typeReg);
  assign timerZero = (waitCnt == '0);
  assign curType   = typeReg;
  assign adcValue  = adcReg;
  assign cfg       = cfgReg;

  always_comb begin
    jigCfg        = '0;
    jigCfg.jigLow   = 1'b1;
    jigCfg.bootHigh = cfgOf(newType).bootHigh;
    cfgNext = cfgReg;
    if (strb.applyNew)      cfgNext = cfgOf(newType);
    else if (strb.applyCur) cfgNext = cfgOf(typeReg);
    else if (strb.jigNew)   cfgNext = jigCfg;
    else if (strb.clearCfg) cfgNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      adcReg    <= '1;
      typeReg   <= DEV_NONE;
      cfgReg    <= '0;
      waitCnt   <= '0;
      changeEvt <= 1'b0;
      attachEvt <= 1'b0;
      detachEvt <= 1'b0;
      keyEvt    <= 1'b0;
    end else begin
      if (strb.latchCode) begin
        adcReg  <= idCode;
        typeReg <= newType;
      end
      cfgReg <= cfgNext;
      if (strb.loadTimer)          waitCnt <= waitTicks;
      else if (tick1k && !timerZero) waitCnt <= waitCnt - 1'b1;
      changeEvt <= strb.latchCode;
      attachEvt <= strb.pulseAttach;
      detachEvt <= strb.pulseDetach;
      keyEvt    <= strb.pulseKey;
    end
  end

  a_r2_change_marks_update: assert property (@(posedge clk) disable iff (!rstN)
    changeEvt |-> (adcReg != $past(adcReg)) || (typeReg != $past(typeReg)));
  a_r8_chg_only_charger: assert property (@(posedge clk) disable iff (!rstN)
    cfgReg.chgLow |-> typeReg == DEV_CHARGER);
  a_r10_none_all_open: assert property (@(posedge clk) disable iff (!rstN)
    (typeReg == DEV_NONE) |-> (cfgReg.path == PATH_OPEN) && !cfgReg.fetOn && !cfgReg.jigLow);
  a_r4_boot_needs_jig: assert property (@(posedge clk) disable iff (!rstN)
    cfgReg.bootHigh |-> cfgReg.jigLow);
  a_r9_key_only_headset: assert property (@(posedge clk) disable iff (!rstN)
    keyEvt |-> typeReg == DEV_AUDIO1);
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtSeen,
  input  devType_t    newType,
  input  devType_t    curType,
  input  logic        intRead,
  input  logic        ioSupplyOk,
  input  logic        timerZero,
  output ctrlStrobe_t strb,
  output phase_t      phase
);
  phase_t nextPhase;

  always_comb begin
    strb      = '0;
    nextPhase = phase;
    if (evtSeen) begin
      strb.latchCode = 1'b1;
      if (newType == curType) begin
        strb.pulseKey = (newType == DEV_AUDIO1);
      end else if (newType == DEV_NONE) begin
        strb.clearCfg    = 1'b1;
        strb.pulseDetach = 1'b1;
        nextPhase        = PH_IDLE;
      end else begin
        strb.pulseAttach = 1'b1;
        if (isFactory(newType)) begin
          if (ioSupplyOk) begin
            strb.applyNew = 1'b1;
            nextPhase     = PH_ACTIVE;
          end else begin
            strb.jigNew = 1'b1;
            nextPhase   = PH_JIG_HOLD;
          end
        end else begin
          strb.clearCfg = 1'b1;
          nextPhase     = PH_WAIT_READ;
        end
      end
    end else begin
      case (phase)
        PH_WAIT_READ: if (intRead) begin
          strb.loadTimer = 1'b1;
          nextPhase      = PH_WAIT_TIME;
        end
        PH_WAIT_TIME: if (timerZero) begin
          strb.applyCur = 1'b1;
          nextPhase     = PH_ACTIVE;
        end
        PH_JIG_HOLD: if (ioSupplyOk) begin
          strb.applyCur = 1'b1;
          nextPhase     = PH_ACTIVE;
        end
        default: nextPhase = phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end

  a_r7_read_ignored_active: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACTIVE && intRead && !evtSeen) |=> phase == PH_ACTIVE);
endmodule

// File: rtl/acc_id_ctrl.sv
module acc_id_ctrl
  import acc_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        idCode,
  input  logic              vbusOk,
  input  logic              ioSupplyOk,
  input  logic              tick1k,
  input  logic [WAIT_W-1:0] waitTicks,
  input  logic              intRead,
  output logic [2:0]        pathSel,
  output logic              chgFetOn,
  output logic              chgDetPullLow,
  output logic              bootHigh,
  output logic              jigPullLow,
  output logic [3:0]        devType,
  output logic [4:0]        adcValue,
  output logic              changeEvt,
  output logic              attachEvt,
  output logic              detachEvt,
  output logic              keyEvt
);
  ctrlStrobe_t strb;
  devType_t    newType, curType;
  logic        evtSeen, timerZero;
  swCfg_t      cfg;
  phase_t      phase;

  acc_dp #(.WAIT_W(WAIT_W)) dp_i (
    .clk(clk), .rstN(rstN), .idCode(idCode), .vbusOk(vbusOk), .tick1k(tick1k),
    .waitTicks(waitTicks), .strb(strb), .newType(newType), .curType(curType),
    .evtSeen(evtSeen), .timerZero(timerZero), .adcValue(adcValue), .cfg(cfg),
    .changeEvt(changeEvt), .attachEvt(attachEvt), .detachEvt(detachEvt), .keyEvt(keyEvt)
  );

  acc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .evtSeen(evtSeen), .newType(newType), .curType(curType),
    .intRead(intRead), .ioSupplyOk(ioSupplyOk), .timerZero(timerZero),
    .strb(strb), .phase(phase)
  );

  assign pathSel       = cfg.path;
  assign chgFetOn      = cfg.fetOn;
  assign chgDetPullLow = cfg.chgLow;
  assign bootHigh      = cfg.bootHigh;
  assign jigPullLow    = cfg.jigLow;
  assign devType       = curType;

  a_r6_open_while_pending: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_WAIT_READ || phase == PH_WAIT_TIME) |->
      (pathSel == 3'd0) && !chgFetOn && !chgDetPullLow && !jigPullLow);
  a_r5_hold_keeps_open: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_JIG_HOLD) |-> jigPullLow && (pathSel == 3'd0));
endmodule

// File: tb/acc_id_ctrl_tb_top.sv
`timescale 1ns/1ps
module acc_id_ctrl_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [4:0] idCode = 5'h1F;
  logic vbusOk = 1'b0, ioSupplyOk = 1'b1, tick1k = 1'b0, intRead = 1'b0;
  logic [7:0] waitTicks = 8'd3;
  logic [2:0] pathSel;
  logic chgFetOn, chgDetPullLow, bootHigh, jigPullLow;
  logic [3:0] devType;
  logic [4:0] adcValue;
  logic changeEvt, attachEvt, detachEvt, keyEvt;

  int checks = 0, errors = 0;
  bit done = 0, started = 0;

  always #5 clk = ~clk;

  acc_id_ctrl #(.WAIT_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .idCode(idCode), .vbusOk(vbusOk), .ioSupplyOk(ioSupplyOk),
    .tick1k(tick1k), .waitTicks(waitTicks), .intRead(intRead), .pathSel(pathSel),
    .chgFetOn(chgFetOn), .chgDetPullLow(chgDetPullLow), .bootHigh(bootHigh),
    .jigPullLow(jigPullLow), .devType(devType), .adcValue(adcValue),
    .changeEvt(changeEvt), .attachEvt(attachEvt), .detachEvt(detachEvt), .keyEvt(keyEvt)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // expected behaviour written from the requirement list
  function automatic int refType(input int code, input bit vb);
    if (code == 0) return 1;
    if (code >= 1 && code <= 13) return 2;
    case (code)
      19: return 3;
      20: return 4;
      21: return 13;
      22: return 5;
      26: return 6;
      24: return 9;
      25: return 10;
      28: return 11;
      29: return 12;
      30: return 2;
      23, 27: return vb ? 7 : 0;
      31: return vb ? 8 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic int refPath(input int t);
    if (t == 1 || t == 8 || t == 9 || t == 10) return 1;
    if (t == 3 || t == 5 || t == 11 || t == 12) return 2;
    if (t == 2 || t == 4 || t == 13) return 3;
    if (t == 6) return 4;
    return 0;
  endfunction

  // reference model state
  int mPh = 0, mType = 0, mAdc = 31, mCnt = 0, mPath = 0;
  bit mFet = 0, mChg = 0, mBoot = 0, mJig = 0;
  bit eChg = 0, eAtt = 0, eDet = 0, eKey = 0;

  task automatic mOpen();
    mPath = 0; mFet = 0; mChg = 0; mBoot = 0; mJig = 0;
  endtask

  task automatic mApply(input int t);
    mPath = refPath(t);
    mFet  = (t == 4 || t == 7 || t == 8 || t == 9 || t == 10);
    mChg  = (t == 7);
    mBoot = (t == 10 || t == 12);
    mJig  = (t >= 9 && t <= 12);
  endtask

  always @(posedge clk) begin
    int nt;
    if (!rstN) begin
      mPh = 0; mType = 0; mAdc = 31; mCnt = 0; mOpen();
      eChg = 0; eAtt = 0; eDet = 0; eKey = 0;
    end else begin
      eChg = 0; eAtt = 0; eDet = 0; eKey = 0;
      nt = refType(int'(idCode), vbusOk);
      if (int'(idCode) != mAdc || nt != mType) begin
        eChg = 1;
        if (nt == mType) eKey = (nt == 2);
        else if (nt == 0) begin mOpen(); eDet = 1; mPh = 0; end
        else begin
          eAtt = 1;
          if (nt >= 9 && nt <= 12) begin
            if (ioSupplyOk) begin mApply(nt); mPh = 4; end
            else begin mOpen(); mJig = 1; mBoot = (nt == 10 || nt == 12); mPh = 3; end
          end else begin mOpen(); mPh = 1; end
        end
        mAdc = int'(idCode); mType = nt;
      end else begin
        if (mPh == 1 && intRead) begin mCnt = int'(waitTicks); mPh = 2; end
        else if (mPh == 2) begin
          if (mCnt == 0) begin mApply(mType); mPh = 4; end
          else if (tick1k) mCnt--;
        end else if (mPh == 3 && ioSupplyOk) begin mApply(mType); mPh = 4; end
      end
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (started) begin
      chk(int'(pathSel) == mPath, "R3", "pathSel", int'(pathSel), mPath);
      chk(chgFetOn == mFet, "R3", "chgFetOn", chgFetOn, mFet);
      chk(chgDetPullLow == mChg, "R8", "chgDetPullLow", chgDetPullLow, mChg);
      chk(bootHigh == mBoot, "R4", "bootHigh", bootHigh, mBoot);
      chk(jigPullLow == mJig, "R4", "jigPullLow", jigPullLow, mJig);
      chk(int'(adcValue) == mAdc, "R2", "adcValue", int'(adcValue), mAdc);
      chk(int'(devType) == mType, "R3", "devType", int'(devType), mType);
      chk(changeEvt == eChg, "R2", "changeEvt", changeEvt, eChg);
      chk(attachEvt == eAtt, "R6", "attachEvt", attachEvt, eAtt);
      chk(detachEvt == eDet, "R10", "detachEvt", detachEvt, eDet);
      chk(keyEvt == eKey, "R9", "keyEvt", keyEvt, eKey);
    end
  end

  // scaled 1 kHz timebase: one pulse every 5 cycles
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % 5;
      tick1k = (k == 0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostRead();
    @(negedge clk) intRead = 1'b1;
    @(negedge clk) intRead = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    started = 1;
    @(negedge clk);
    // R1 reset state
    chk(pathSel == 0 && !chgFetOn && !chgDetPullLow && !bootHigh && !jigPullLow,
        "R1", "outputs idle", int'(pathSel), 0);
    chk(adcValue == 5'h1F && devType == 0, "R1", "code/type", int'(adcValue), 31);

    // R11 USB via VBUS on 11111, R6 handshake
    vbusOk = 1'b1;
    @(negedge clk);
    chk(devType == 8, "R11", "usb type", int'(devType), 8);
    chk(changeEvt && attachEvt, "R2", "change+attach", int'(changeEvt), 1);
    cyc(12);
    chk(pathSel == 0, "R6", "open before read", int'(pathSel), 0);
    hostRead();
    cyc(25);
    chk(pathSel == 1 && chgFetOn, "R6", "usb applied", int'(pathSel), 1);
    hostRead();
    cyc(2);
    chk(pathSel == 1, "R7", "read ignored", int'(pathSel), 1);

    // R10 detach
    @(negedge clk) vbusOk = 1'b0;
    @(negedge clk);
    chk(devType == 0 && pathSel == 0 && !chgFetOn, "R10", "detach", int'(devType), 0);
    chk(detachEvt == 1'b1, "R10", "detachEvt", int'(detachEvt), 1);

    // headset with buttons, R9 / R11
    idCode = 5'b11110;
    @(negedge clk);
    chk(devType == 2, "R11", "11110 headset", int'(devType), 2);
    hostRead();
    cyc(25);
    chk(pathSel == 3, "R3", "audio path", int'(pathSel), 3);
    idCode = 5'b00101;
    @(negedge clk);
    chk(keyEvt && adcValue == 5 && pathSel == 3, "R9", "button key", int'(keyEvt), 1);
    idCode = 5'b11110;
    cyc(3);
    chk(pathSel == 3 && !attachEvt, "R9", "release keeps cfg", int'(pathSel), 3);

    // reserved code detaches, R10
    idCode = 5'b01111;
    @(negedge clk);
    chk(devType == 0 && pathSel == 0, "R10", "reserved code", int'(devType), 0);

    // charger, R8
    idCode = 5'b10111;
    @(negedge clk);
    chk(devType == 0, "R8", "no vbus charger", int'(devType), 0);
    waitTicks = 8'd0;
    vbusOk = 1'b1;
    @(negedge clk);
    chk(devType == 7, "R8", "charger type", int'(devType), 7);
    hostRead();
    @(negedge clk);
    chk(chgDetPullLow && chgFetOn && pathSel == 0, "R8", "charger cfg", int'(chgDetPullLow), 1);
    vbusOk = 1'b0;
    @(negedge clk);
    chk(!chgDetPullLow && !chgFetOn, "R8", "vbus lost", int'(chgDetPullLow), 0);

    // factory with supply, R4
    idCode = 5'b11001;
    @(negedge clk);
    chk(pathSel == 1 && bootHigh && jigPullLow, "R4", "jig usb boot on", int'(pathSel), 1);

    // factory without supply, R5
    ioSupplyOk = 1'b0;
    idCode = 5'b11100;
    @(negedge clk);
    chk(jigPullLow && !bootHigh && pathSel == 0, "R5", "jig held", int'(pathSel), 0);
    cyc(4);
    chk(pathSel == 0, "R5", "still open", int'(pathSel), 0);
    ioSupplyOk = 1'b1;
    @(negedge clk);
    chk(pathSel == 2 && jigPullLow, "R5", "uart applied", int'(pathSel), 2);

    // A/V cable, then UART cable while the timer runs
    waitTicks = 8'd4;
    idCode = 5'b11010;
    @(negedge clk);
    chk(!jigPullLow && pathSel == 0, "R6", "av pending", int'(pathSel), 0);
    hostRead();
    cyc(3);
    idCode = 5'b10110;
    cyc(2);
    hostRead();
    cyc(30);
    chk(pathSel == 2 && devType == 5, "R3", "uart cable", int'(pathSel), 2);
    idCode = 5'b00000;
    cyc(3);
    intRead = 1'b0;
    cyc(20);
    chk(pathSel == 0, "R7", "no read no cfg", int'(pathSel), 0);
    hostRead();
    cyc(30);
    chk(pathSel == 1 && !chgFetOn, "R3", "otg", int'(pathSel), 1);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule